// File: doc/BRIEF.md
# Priority Memory Map Decoder

This block turns a 16-bit processor address into a choice among four on-chip targets: a window of I/O registers, an EEPROM area, a non-volatile RAM area and internal RAM. The targets may overlap, and a fixed priority decides which one answers. An address that no target claims is flagged for external memory. The I/O window and the RAM region can be moved at run time. An 8-bit init register holds their bases as two nibbles, and that register sits inside the I/O window itself.

Each access presented with `acc_valid` is decoded against the current init value. One clock later the block gives registered results: a one-hot select, the offset of the address within the chosen region, and an external-access flag. A static input chooses between a small and a large I/O window. The memories behind the selects and the bus timing sit outside this block.

Top module: `memmap_prio_decoder`

## Requirements
- R1: Every access with `acc_valid` high gives, one clock later, either exactly one bit of `rgn_sel` set or `ext_access` set, never both. The select bits are: bit 0 I/O, bit 1 EEPROM, bit 2 non-volatile RAM, bit 3 internal RAM.
- R2: Where regions overlap, the I/O window wins over EEPROM, EEPROM wins over non-volatile RAM, and non-volatile RAM wins over internal RAM.
- R3: The I/O window starts at the init register's bits 3:0 shifted left by 12. It spans 64 bytes when `big_io_win` is 0 and 1024 bytes when it is 1.
- R4: Internal RAM starts at the init register's bits 7:4 shifted left by 8 and spans RAM_SIZE bytes (default 256).
- R5: A write access (`acc_write` high) to I/O window offset INIT_OFF (default 0x3D) loads `acc_wdata` into the init register. That access itself decodes with the old value and the next one uses the new value. A read at that offset, or a write at any other address, leaves the register unchanged. `init_val` shows the register.
- R6: An access that matches no region sets `ext_access` and drives every select low.
- R7: `rgn_off` is the address minus the base of the selected region, and 0 on an external access.
- R8: A synchronous reset loads the init register with INIT_RST (default 0x01) and clears all outputs. A cycle without `acc_valid` gives all-zero selects, offset and flag on the next clock.
- R9: EEPROM occupies EE_BASE..EE_BASE+EE_SIZE-1 (default 0xB200, 512 bytes). Non-volatile RAM occupies NV_BASE..NV_BASE+NV_SIZE-1 (default 0x0800, 2048 bytes).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_io_win | input | 1 | 1 selects the large I/O window, 0 the small one |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| rgn_sel | output | 4 | Registered one-hot region select |
| rgn_off | output | 16 | Registered offset within the selected region |
| ext_access | output | 1 | Registered flag: no internal region matched |
| init_val | output | 8 | Current init register value |

## Verification
The assertions check on every cycle that the select is one-hot or empty, that a miss never comes with a select, that each valid access yields a result one clock later and an idle cycle yields none, that an I/O hit always wins, and that the init register changes only on a matching write. Only the bench scenarios can show the region boundaries in each window size, the moves of the I/O and RAM bases after init writes, the old-value decode of the write cycle itself, and the overlap cases where RAM is hidden by the I/O window or by non-volatile RAM.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int NUM_RGN = 4;

  // Index of each region in the select vector; lower index has priority.
  typedef enum int {
    RGN_IO  = 0,
    RGN_EE  = 1,
    RGN_NV  = 2,
    RGN_RAM = 3
  } rgn_idx_e;
endpackage

// File: rtl/mmd_window.sv
module mmd_window #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              hit,
  output logic [ADDR_W-1:0] off
);
  // Modular distance from base; in range when below the window size.
  always_comb begin
    off = addr - base;
    hit = (off < size);
  end
endmodule

// File: rtl/mmd_init_reg.sv
module mmd_init_reg #(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  RST_VAL = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] init_q
);
  always_ff @(posedge clk) begin
    if (rst)        init_q <= DATA_W'(RST_VAL);
    else if (wr_en) init_q <= wdata;
  end

  // R5: a matching write loads the data
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> init_q == $past(wdata));
  // R5: without a matching write the register holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(init_q));
endmodule

// File: rtl/mmd_prio_pick.sv
module mmd_prio_pick #(
  parameter int N      = 4,
  parameter int ADDR_W = 16
) (
  input  logic [N-1:0]             hits,
  input  logic [N-1:0][ADDR_W-1:0] offs,
  output logic [N-1:0]             sel,
  output logic [ADDR_W-1:0]        off,
  output logic                     miss
);
  // Lowest index that hits wins.
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    off   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && hits[i]) begin
        sel[i] = 1'b1;
        off    = offs[i];
        found  = 1'b1;
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/memmap_prio_decoder.sv
module memmap_prio_decoder
  import mmd_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         EE_BASE     = 'hB200,
  parameter int         EE_SIZE     = 'h200,
  parameter int         NV_BASE     = 'h0800,
  parameter int         NV_SIZE     = 'h800,
  parameter int         RAM_SIZE    = 'h100,
  parameter int         IO_SMALL_SZ = 'h40,
  parameter int         IO_LARGE_SZ = 'h400,
  parameter int         INIT_OFF    = 'h3D,
  parameter logic [7:0] INIT_RST    = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_io_win,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [NUM_RGN-1:0] rgn_sel,
  output logic [ADDR_W-1:0] rgn_off,
  output logic              ext_access,
  output logic [DATA_W-1:0] init_val
);
  localparam int IO_SHIFT  = ADDR_W - 4;
  localparam int RAM_SHIFT = ADDR_W - 8;

  logic [DATA_W-1:0]              init_q;
  logic [NUM_RGN-1:0][ADDR_W-1:0] win_base;
  logic [NUM_RGN-1:0][ADDR_W-1:0] win_size;
  logic [NUM_RGN-1:0]             win_hit;
  logic [NUM_RGN-1:0][ADDR_W-1:0] win_off;
  logic [NUM_RGN-1:0]             pick_sel;
  logic [ADDR_W-1:0]              pick_off;
  logic                           pick_miss;
  logic                           init_wr;

  // Region bases and sizes; the I/O and RAM bases come from init nibbles.
  always_comb begin
    win_base[RGN_IO]  = ADDR_W'(init_q[3:0]) << IO_SHIFT;
    win_size[RGN_IO]  = big_io_win ? ADDR_W'(IO_LARGE_SZ) : ADDR_W'(IO_SMALL_SZ);
    win_base[RGN_EE]  = ADDR_W'(EE_BASE);
    win_size[RGN_EE]  = ADDR_W'(EE_SIZE);
    win_base[RGN_NV]  = ADDR_W'(NV_BASE);
    win_size[RGN_NV]  = ADDR_W'(NV_SIZE);
    win_base[RGN_RAM] = ADDR_W'(init_q[7:4]) << RAM_SHIFT;
    win_size[RGN_RAM] = ADDR_W'(RAM_SIZE);
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
    mmd_window #(.ADDR_W(ADDR_W)) u_win (
      .addr (acc_addr),
      .base (win_base[g]),
      .size (win_size[g]),
      .hit  (win_hit[g]),
      .off  (win_off[g])
    );
  end

  mmd_prio_pick #(.N(NUM_RGN), .ADDR_W(ADDR_W)) u_pick (
    .hits (win_hit),
    .offs (win_off),
    .sel  (pick_sel),
    .off  (pick_off),
    .miss (pick_miss)
  );

  assign init_wr = acc_valid && acc_write && win_hit[RGN_IO]
                   && (win_off[RGN_IO] == ADDR_W'(INIT_OFF));

  mmd_init_reg #(.DATA_W(DATA_W), .RST_VAL(INIT_RST)) u_init (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (init_wr),
    .wdata  (acc_wdata),
    .init_q (init_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      rgn_sel    <= '0;
      rgn_off    <= '0;
      ext_access <= 1'b0;
    end else begin
      rgn_sel    <= pick_sel;
      rgn_off    <= pick_off;
      ext_access <= pick_miss;
    end
  end

  assign init_val = init_q;

  // R1: at most one region selected
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgn_sel));
  // R1: each valid access yields a select or a miss next cycle
  a_r1_result: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (rgn_sel != '0) || ext_access);
  // R6: a miss never comes with a select
  a_r6_miss_clear: assert property (@(posedge clk) disable iff (rst)
    ext_access |-> rgn_sel == '0);
  // R2: an I/O window hit always wins
  a_r2_io_wins: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && win_hit[RGN_IO]) |=> rgn_sel[RGN_IO]);
  // R8: idle cycle gives empty outputs
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (rgn_sel == '0) && !ext_access && (rgn_off == '0));
endmodule

// File: tb/memmap_prio_decoder_test.sv
`timescale 1ns/100ps
module memmap_prio_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        big_io_win;
  logic        acc_valid;
  logic        acc_write;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wdata;
  logic [3:0]  rgn_sel;
  logic [15:0] rgn_off;
  logic        ext_access;
  logic [7:0]  init_val;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int    m_init;
  int    e_sel, e_off, e_ext, e_init;
  string e_tag;

  always #2.5 clk = ~clk;

  memmap_prio_decoder uut (
    .clk(clk), .rst(rst), .big_io_win(big_io_win),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rgn_sel(rgn_sel), .rgn_off(rgn_off),
    .ext_access(ext_access), .init_val(init_val)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit inside_rng(int a, int base, int size);
    return (a >= base) && (a < base + size);
  endfunction

  // Compare what the previous step predicted, then drive and predict next.
  task automatic step(bit r, bit v, bit w, int a, int d, bit big, string tag);
    int io_b, io_s, ram_b;
    check(e_tag, "sel", int'(rgn_sel), e_sel);
    check(e_tag, "off", int'(rgn_off), e_off);
    check(e_tag, "ext", int'(ext_access), e_ext);
    check(e_tag, "init", int'(init_val), e_init);
    io_b  = (m_init & 15) << 12;
    io_s  = big ? 1024 : 64;
    ram_b = (m_init >> 4) << 8;
    e_sel = 0; e_off = 0; e_ext = 0;
    if (r) begin
      m_init = 'h01;
    end else if (v) begin
      if (inside_rng(a, io_b, io_s)) begin
        e_sel = 1; e_off = a - io_b;
        if (w && (a - io_b) == 'h3D) m_init = d;
      end else if (inside_rng(a, 'hB200, 'h200)) begin
        e_sel = 2; e_off = a - 'hB200;
      end else if (inside_rng(a, 'h0800, 'h800)) begin
        e_sel = 4; e_off = a - 'h0800;
      end else if (inside_rng(a, ram_b, 'h100)) begin
        e_sel = 8; e_off = a - ram_b;
      end else begin
        e_ext = 1;
      end
    end
    e_init = m_init;
    e_tag  = tag;
    rst = r; acc_valid = v; acc_write = w;
    acc_addr = 16'(a); acc_wdata = 8'(d); big_io_win = big;
    @(negedge clk);
  endtask

  task automatic rd(int a, bit big, string tag);
    step(0, 1, 0, a, 0, big, tag);
  endtask

  initial begin
    rst = 1; acc_valid = 0; acc_write = 0; acc_addr = 0;
    acc_wdata = 0; big_io_win = 0;
    m_init = 'h01; e_sel = 0; e_off = 0; e_ext = 0; e_init = 'h01;
    e_tag = "R8";
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");          // reset state shows here
    step(0, 0, 0, 'h1000, 0, 0, "R8");     // idle
    rd('h1000, 0, "R3");
    rd('h103F, 0, "R3");
    rd('h1040, 0, "R6");                   // past small window
    rd('h1040, 1, "R3");                   // inside large window
    rd('h13FF, 1, "R7");
    rd('h1400, 1, "R6");
    rd('h00FF, 0, "R4");
    rd('h0100, 0, "R6");
    rd('hB200, 0, "R9");
    rd('hB3FF, 0, "R9");
    rd('hB400, 0, "R6");
    rd('h0800, 0, "R9");
    rd('h0FFF, 0, "R9");
    rd('h103D, 0, "R5");                   // read leaves init alone
    step(0, 1, 1, 'h103C, 'h55, 0, "R5");  // wrong offset
    step(0, 1, 1, 'h103D, 'h8B, 0, "R5");  // decodes with old base
    rd('h1000, 0, "R5");                   // old I/O base gone
    rd('hB03D, 0, "R5");
    rd('h0810, 0, "R2");                   // NV hides moved RAM
    rd('hB200, 0, "R2");                   // EE beyond small window
    rd('hB200, 1, "R2");                   // large I/O hides EE
    step(0, 1, 1, 'hB03D, 'h00, 0, "R5");
    rd('h0010, 0, "R2");                   // I/O hides RAM
    rd('h0040, 0, "R4");
    rd('h0040, 1, "R2");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");          // reset restores init
    step(0, 0, 0, 0, 0, 0, "R8");
    rd('h1001, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule